// File: doc/BRIEF.md
# Outstanding Request Sequencer

This block sits between a processor front end and the request queue of a cache controller. It tracks every memory request that is in flight by its cache-line address. Read-class requests (loads, instruction fetches) live in one small table and write-class requests (stores, locked reads, locked writes) live in another. A request is accepted only if the global in-flight limit is not reached, its own table has a free slot, and no request to the same line is pending in either table. An accepted request is given an ID and translated into the request format of the cache controller, with the access latency that goes with it. It is then issued one cycle later.

Completions come back on a response port that carries the line address and the class (read or write). A completion that matches a pending entry retires that entry and returns the entry's ID. A completion that matches nothing raises a protocol-error pulse.

The block also holds a single-line reservation that pairs locked reads with locked writes. A periodic watchdog raises a sticky deadlock flag when any entry has been pending for too long.

Top module: `mreq_sequencer`

## Requirements
- R1: Request kind codes are 0 load, 1 instruction fetch, 2 store, 3 locked read, 4 locked write. Codes 2, 3 and 4 occupy the write table and codes 0 and 1 occupy the read table, so a completion retires an entry only when `rsp_write` (1 = write class) matches the class of that entry.
- R2: `req_ready` is low when `outstanding` is at or above MAX_OUT, or when the table for the request's class has no free slot.
- R3: `req_ready` is low when the requested line has a pending entry in either table, whatever the request kind.
- R4: `outstanding` always equals the number of entries in both tables. It rises by one per inserted request and falls by one per retiring completion, and it is 0 after reset.
- R5: An entry's age counts the clock edges since it was inserted. At each watchdog check, any entry whose age at that edge is THRESH or more sets `deadlock`, which stays high until reset.
- R6: The watchdog is idle after reset. The first insertion while it is idle arms it, and a check falls every THRESH cycles. After a check the watchdog re-arms if entries remain and goes idle if the tables are empty.
- R7: When a write-class completion retires a locked-read entry, the reservation is set on that line and replaces any earlier reservation.
- R8: An accepted locked write whose line does not hold the reservation is neither issued nor inserted. Instead it produces `lkfail_valid` with its ID on the next cycle. If the line does hold the reservation, the reservation is cleared and the request is issued.
- R9: `iss_kind` is 0 for a load, 1 for an instruction fetch and 2 for any write-class kind. `iss_super` is 1 only for mode code 1 (supervisor). Mode codes 0 (user), 2 (device) and 3 are all issued as user.
- R10: `iss_lat` carries ICACHE_LAT for instruction fetches and DCACHE_LAT for every other kind.
- R11: A completion with no matching entry in the table of its class gives a one-cycle `proto_err` pulse on the next cycle and leaves both tables unchanged.
- R12: Each accepted request, including a locked write that fails, receives the current ID on `req_id` in its accept cycle. The ID then increments by one, modulo 2^ID_W, starting from 0 after reset.
- R13: A retiring completion gives `done_valid` with the stored ID of that entry one cycle later. An accepted request appears on the issue port (`iss_valid` and its fields) one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind code |
| req_mode | input | 2 | Access mode code |
| req_line | input | LINE_W | Cache-line address of the request |
| req_ready | output | 1 | Request would be accepted this cycle |
| req_id | output | ID_W | ID given to a request accepted this cycle |
| iss_valid | output | 1 | Issued request to the cache controller |
| iss_kind | output | 2 | Translated request kind |
| iss_super | output | 1 | Issued in supervisor mode |
| iss_line | output | LINE_W | Line address of the issued request |
| iss_lat | output | LAT_W | Cache access latency for the issued request |
| iss_id | output | ID_W | ID of the issued request |
| lkfail_valid | output | 1 | Locked write failed for lack of reservation |
| lkfail_id | output | ID_W | ID of the failed locked write |
| rsp_valid | input | 1 | Completion present |
| rsp_write | input | 1 | Completion class, 1 = write |
| rsp_line | input | LINE_W | Line address of the completion |
| done_valid | output | 1 | A pending entry retired |
| done_id | output | ID_W | ID of the retired entry |
| proto_err | output | 1 | Completion matched no entry |
| deadlock | output | 1 | Sticky age-watchdog flag |
| outstanding | output | clog2(RD_DEPTH+WR_DEPTH+1) | Number of pending entries |

## Verification
The bench builds the block with a 4-bit line address, three slots in each table and MAX_OUT of 4. With these values the random stream runs into all three refusal causes: same-line collisions, a full table while the global limit still has room, and the global limit with room in both tables. THRESH is set to 16, so both watchdog checks and deadlock detection, including an entry that is caught only at the second check, happen within a few dozen cycles. A 6-bit ID wraps several times during the random run, and distinct instruction and data latencies (2 and 5) make the latency selection visible on the issue port.

// File: rtl/mreq_pkg.sv
package mreq_pkg;

   typedef enum logic [2:0] {
      KIND_LOAD    = 3'd0,
      KIND_IFETCH  = 3'd1,
      KIND_STORE   = 3'd2,
      KIND_LOCK_RD = 3'd3,
      KIND_LOCK_WR = 3'd4
   } req_kind_e;

   typedef enum logic [1:0] {
      ISS_LOAD   = 2'd0,
      ISS_IFETCH = 2'd1,
      ISS_STORE  = 2'd2
   } iss_kind_e;

   localparam logic [1:0] MODE_SUPER = 2'd1;

   function automatic logic kind_is_write(input logic [2:0] k);
      return (k == KIND_STORE) || (k == KIND_LOCK_RD) || (k == KIND_LOCK_WR);
   endfunction

endpackage

// File: rtl/mreq_xlate.sv
module mreq_xlate
   import mreq_pkg::*;
#(
   parameter int LAT_W      = 4,
   parameter int ICACHE_LAT = 2,
   parameter int DCACHE_LAT = 3
) (
   input  logic [2:0]       kind,
   input  logic [1:0]       mode,
   output logic             is_write,
   output logic             is_lock_wr,
   output logic             is_lock_rd,
   output logic [1:0]       iss_kind,
   output logic             iss_super,
   output logic [LAT_W-1:0] iss_lat
);

   always_comb begin
      is_write   = kind_is_write(kind);
      is_lock_wr = (kind == KIND_LOCK_WR);
      is_lock_rd = (kind == KIND_LOCK_RD);
      iss_super  = (mode == MODE_SUPER);
      case (kind)
         KIND_IFETCH:                          iss_kind = ISS_IFETCH;
         KIND_STORE, KIND_LOCK_RD, KIND_LOCK_WR: iss_kind = ISS_STORE;
         default:                              iss_kind = ISS_LOAD;
      endcase
   end

   // latency select collapses to a constant when both caches match
   generate
      if (ICACHE_LAT == DCACHE_LAT) begin : g_lat_same
         assign iss_lat = LAT_W'(DCACHE_LAT);
      end else begin : g_lat_split
         assign iss_lat = (kind == KIND_IFETCH) ? LAT_W'(ICACHE_LAT) : LAT_W'(DCACHE_LAT);
      end
   endgenerate

endmodule

// File: rtl/mreq_track_table.sv
module mreq_track_table #(
   parameter int DEPTH  = 4,
   parameter int LINE_W = 8,
   parameter int ID_W   = 8,
   parameter int THRESH = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [LINE_W-1:0]              look_line,
   output logic                           look_hit,
   input  logic                           ins_en,
   input  logic [LINE_W-1:0]              ins_line,
   input  logic                           ins_lock,
   input  logic [ID_W-1:0]                ins_id,
   input  logic                           del_en,
   input  logic [LINE_W-1:0]              del_line,
   output logic                           del_hit,
   output logic [ID_W-1:0]                del_id,
   output logic                           del_lock,
   output logic                           full,
   output logic [$clog2(DEPTH+1)-1:0]     count,
   output logic                           aged
);

   localparam int CW    = $clog2(DEPTH + 1);
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int AGE_W = $clog2(THRESH);
   localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(THRESH - 1);

   logic [DEPTH-1:0] vld, look_m, del_m, old_m, lock_v;
   logic [ID_W-1:0]  id_v [DEPTH];
   logic [IW-1:0]    free_idx;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic              v_r, lock_r;
         logic [LINE_W-1:0] line_r;
         logic [ID_W-1:0]   id_r;
         logic [AGE_W-1:0]  age_r;
         logic              take;

         assign take = ins_en && !v_r && (free_idx == IW'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_r    <= 1'b0;
               lock_r <= 1'b0;
               line_r <= '0;
               id_r   <= '0;
               age_r  <= '0;
            end else if (take) begin
               v_r    <= 1'b1;
               lock_r <= ins_lock;
               line_r <= ins_line;
               id_r   <= ins_id;
               age_r  <= '0;
            end else if (del_en && del_m[g]) begin
               v_r <= 1'b0;
            end else if (v_r && age_r != AGE_SAT) begin
               age_r <= age_r + AGE_W'(1);
            end
         end

         assign vld[g]    = v_r;
         assign look_m[g] = v_r && (line_r == look_line);
         assign del_m[g]  = v_r && (line_r == del_line);
         // saturated age means THRESH is reached at the coming edge
         assign old_m[g]  = v_r && (age_r == AGE_SAT);
         assign lock_v[g] = lock_r;
         assign id_v[g]   = id_r;
      end
   endgenerate

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld[i]) free_idx = IW'(i);
      end
   end

   always_comb begin
      del_id   = '0;
      del_lock = 1'b0;
      count    = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (del_m[i]) begin
            del_id   = del_id | id_v[i];
            del_lock = del_lock | lock_v[i];
         end
         if (vld[i]) count = count + CW'(1);
      end
   end

   assign look_hit = |look_m;
   assign del_hit  = |del_m;
   assign full     = &vld;
   assign aged     = |old_m;

   a_r3_line_unique : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_m));
   a_r2_no_full_insert : assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !full);

endmodule

// File: rtl/mreq_watchdog.sv
module mreq_watchdog #(
   parameter int THRESH = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic keep,
   input  logic aged,
   output logic active,
   output logic deadlock
);

   localparam int TW = $clog2(THRESH);
   localparam logic [TW-1:0] RELOAD = TW'(THRESH - 1);

   logic [TW-1:0] tmr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         tmr      <= '0;
         deadlock <= 1'b0;
      end else if (!active) begin
         if (arm) begin
            active <= 1'b1;
            tmr    <= RELOAD;
         end
      end else if (tmr == '0) begin
         if (aged) deadlock <= 1'b1;
         if (keep) tmr <= RELOAD;
         else      active <= 1'b0;
      end else begin
         tmr <= tmr - TW'(1);
      end
   end

   a_r5_deadlock_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> deadlock);

endmodule

// File: rtl/mreq_sequencer.sv
module mreq_sequencer #(
   parameter int LINE_W     = 8,
   parameter int ID_W       = 8,
   parameter int RD_DEPTH   = 4,
   parameter int WR_DEPTH   = 4,
   parameter int MAX_OUT    = 6,
   parameter int THRESH     = 64,
   parameter int LAT_W      = 4,
   parameter int ICACHE_LAT = 2,
   parameter int DCACHE_LAT = 3
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   input  logic [2:0]                                req_kind,
   input  logic [1:0]                                req_mode,
   input  logic [LINE_W-1:0]                         req_line,
   output logic                                      req_ready,
   output logic [ID_W-1:0]                           req_id,
   output logic                                      iss_valid,
   output logic [1:0]                                iss_kind,
   output logic                                      iss_super,
   output logic [LINE_W-1:0]                         iss_line,
   output logic [LAT_W-1:0]                          iss_lat,
   output logic [ID_W-1:0]                           iss_id,
   output logic                                      lkfail_valid,
   output logic [ID_W-1:0]                           lkfail_id,
   input  logic                                      rsp_valid,
   input  logic                                      rsp_write,
   input  logic [LINE_W-1:0]                         rsp_line,
   output logic                                      done_valid,
   output logic [ID_W-1:0]                           done_id,
   output logic                                      proto_err,
   output logic                                      deadlock,
   output logic [$clog2(RD_DEPTH+WR_DEPTH+1)-1:0]    outstanding
);

   localparam int CNT_W = $clog2(RD_DEPTH + WR_DEPTH + 1);
   localparam int RC_W  = $clog2(RD_DEPTH + 1);
   localparam int WC_W  = $clog2(WR_DEPTH + 1);

   generate
      if (MAX_OUT < 1 || MAX_OUT > RD_DEPTH + WR_DEPTH) begin : g_bad_max
         $error("MAX_OUT must lie between 1 and the sum of both table depths");
      end
      if (THRESH < 2) begin : g_bad_thresh
         $error("THRESH must be at least 2");
      end
      if (ICACHE_LAT >= (1 << LAT_W) || DCACHE_LAT >= (1 << LAT_W)) begin : g_bad_lat
         $error("latencies must fit in LAT_W bits");
      end
   endgenerate

   // request decode
   logic             k_write, k_lock_wr, k_lock_rd, k_super;
   logic [1:0]       k_iss;
   logic [LAT_W-1:0] k_lat;

   mreq_xlate #(.LAT_W(LAT_W), .ICACHE_LAT(ICACHE_LAT), .DCACHE_LAT(DCACHE_LAT)) u_xlate (
      .kind(req_kind), .mode(req_mode), .is_write(k_write), .is_lock_wr(k_lock_wr),
      .is_lock_rd(k_lock_rd), .iss_kind(k_iss), .iss_super(k_super), .iss_lat(k_lat)
   );

   // tables
   logic              rd_hit, wr_hit, rd_del_hit, wr_del_hit, rd_full, wr_full;
   logic              rd_aged, wr_aged, rd_del_lock, wr_del_lock;
   logic [ID_W-1:0]   rd_del_id, wr_del_id;
   logic [RC_W-1:0]   rd_count;
   logic [WC_W-1:0]   wr_count;
   logic              ins, ins_rd, ins_wr, acc, lk_fail;
   logic [ID_W-1:0]   id_ctr;

   mreq_track_table #(.DEPTH(RD_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .THRESH(THRESH)) u_rd_tbl (
      .clk(clk), .rst_n(rst_n), .look_line(req_line), .look_hit(rd_hit),
      .ins_en(ins_rd), .ins_line(req_line), .ins_lock(1'b0), .ins_id(id_ctr),
      .del_en(rsp_valid && !rsp_write), .del_line(rsp_line), .del_hit(rd_del_hit),
      .del_id(rd_del_id), .del_lock(rd_del_lock), .full(rd_full), .count(rd_count),
      .aged(rd_aged)
   );

   mreq_track_table #(.DEPTH(WR_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .THRESH(THRESH)) u_wr_tbl (
      .clk(clk), .rst_n(rst_n), .look_line(req_line), .look_hit(wr_hit),
      .ins_en(ins_wr), .ins_line(req_line), .ins_lock(k_lock_rd), .ins_id(id_ctr),
      .del_en(rsp_valid && rsp_write), .del_line(rsp_line), .del_hit(wr_del_hit),
      .del_id(wr_del_id), .del_lock(wr_del_lock), .full(wr_full), .count(wr_count),
      .aged(wr_aged)
   );

   // admission
   logic             rsv_v;
   logic [LINE_W-1:0] rsv_line;
   logic             rsv_match, class_full;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;

   assign class_full = k_write ? wr_full : rd_full;
   assign req_ready  = (cnt_q < CNT_W'(MAX_OUT)) && !rd_hit && !wr_hit && !class_full;
   assign acc        = req_valid && req_ready;
   assign rsv_match  = rsv_v && (rsv_line == req_line);
   assign lk_fail    = acc && k_lock_wr && !rsv_match;
   assign ins        = acc && !lk_fail;
   assign ins_rd     = ins && !k_write;
   assign ins_wr     = ins && k_write;
   assign req_id     = id_ctr;

   // completion
   logic            rsp_hit, rsp_lock;
   logic [ID_W-1:0] rsp_id;

   assign rsp_hit  = rsp_valid && (rsp_write ? wr_del_hit : rd_del_hit);
   assign rsp_lock = rsp_write ? wr_del_lock : rd_del_lock;
   assign rsp_id   = rsp_write ? wr_del_id : rd_del_id;

   always_comb begin
      cnt_nxt = cnt_q;
      if (ins)     cnt_nxt = cnt_nxt + CNT_W'(1);
      if (rsp_hit) cnt_nxt = cnt_nxt - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q        <= '0;
         id_ctr       <= '0;
         rsv_v        <= 1'b0;
         rsv_line     <= '0;
         iss_valid    <= 1'b0;
         iss_kind     <= '0;
         iss_super    <= 1'b0;
         iss_line     <= '0;
         iss_lat      <= '0;
         iss_id       <= '0;
         lkfail_valid <= 1'b0;
         lkfail_id    <= '0;
         done_valid   <= 1'b0;
         done_id      <= '0;
         proto_err    <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         if (acc) id_ctr <= id_ctr + ID_W'(1);
         // a fresh locked-read completion wins over a same-cycle clear
         if (rsp_hit && rsp_write && rsp_lock) begin
            rsv_v    <= 1'b1;
            rsv_line <= rsp_line;
         end else if (acc && k_lock_wr && rsv_match) begin
            rsv_v <= 1'b0;
         end
         iss_valid    <= ins;
         iss_kind     <= k_iss;
         iss_super    <= k_super;
         iss_line     <= req_line;
         iss_lat      <= k_lat;
         iss_id       <= id_ctr;
         lkfail_valid <= lk_fail;
         lkfail_id    <= id_ctr;
         done_valid   <= rsp_hit;
         done_id      <= rsp_id;
         proto_err    <= rsp_valid && !rsp_hit;
      end
   end

   assign outstanding = cnt_q;

   // watchdog
   logic wd_active;

   mreq_watchdog #(.THRESH(THRESH)) u_wd (
      .clk(clk), .rst_n(rst_n), .arm(ins), .keep(cnt_nxt != '0),
      .aged(rd_aged || wr_aged), .active(wd_active), .deadlock(deadlock)
   );

   a_r2_cap_limit : assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CNT_W'(MAX_OUT));
   a_r4_count_sum : assert property (@(posedge clk) disable iff (!rst_n)
      outstanding == CNT_W'(rd_count) + CNT_W'(wr_count));
   a_r3_one_table : assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_hit && wr_hit));
   a_r8_fail_not_issued : assert property (@(posedge clk) disable iff (!rst_n)
      lkfail_valid |-> !iss_valid);
   a_r9_kind_range : assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> iss_kind != 2'd3);
   a_r6_wd_armed : assert property (@(posedge clk) disable iff (!rst_n)
      (outstanding != '0) |-> wd_active);
   a_r13_done_follows_rsp : assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(rsp_valid));

endmodule

// File: tb/mreq_sequencer_tb.sv
module mreq_sequencer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LINE_W = 4;
   localparam int ID_W   = 6;
   localparam int RD_D   = 3;
   localparam int WR_D   = 3;
   localparam int MAXO   = 4;
   localparam int THR    = 16;
   localparam int LAT_W  = 4;
   localparam int ILAT   = 2;
   localparam int DLAT   = 5;
   localparam int NL     = 1 << LINE_W;
   localparam int CNT_W  = $clog2(RD_D + WR_D + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, rsp_valid = 1'b0, rsp_write = 1'b0;
   logic [2:0] req_kind = '0;
   logic [1:0] req_mode = '0;
   logic [LINE_W-1:0] req_line = '0, rsp_line = '0;
   logic req_ready, iss_valid, iss_super, lkfail_valid, done_valid, proto_err, deadlock;
   logic [ID_W-1:0] req_id, iss_id, lkfail_id, done_id;
   logic [1:0] iss_kind;
   logic [LINE_W-1:0] iss_line;
   logic [LAT_W-1:0] iss_lat;
   logic [CNT_W-1:0] outstanding;

   mreq_sequencer #(.LINE_W(LINE_W), .ID_W(ID_W), .RD_DEPTH(RD_D), .WR_DEPTH(WR_D),
      .MAX_OUT(MAXO), .THRESH(THR), .LAT_W(LAT_W), .ICACHE_LAT(ILAT), .DCACHE_LAT(DLAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .req_mode(req_mode),
      .req_line(req_line), .req_ready(req_ready), .req_id(req_id), .iss_valid(iss_valid),
      .iss_kind(iss_kind), .iss_super(iss_super), .iss_line(iss_line), .iss_lat(iss_lat),
      .iss_id(iss_id), .lkfail_valid(lkfail_valid), .lkfail_id(lkfail_id),
      .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_line(rsp_line),
      .done_valid(done_valid), .done_id(done_id), .proto_err(proto_err),
      .deadlock(deadlock), .outstanding(outstanding)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;

   // reference model state
   bit m_v [NL];
   bit m_w [NL];
   bit m_lk [NL];
   int m_id [NL];
   int m_age [NL];
   int m_cnt, rsv_ln, next_id, wd_tmr;
   bit rsv_v, wd_act, m_dead;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit is_wr(input int k);
      return (k == 2) || (k == 3) || (k == 4);
   endfunction

   function automatic int tcount(input bit w);
      int c = 0;
      for (int i = 0; i < NL; i++) if (m_v[i] && m_w[i] == w) c++;
      return c;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NL; i++) begin
         m_v[i] = 0; m_w[i] = 0; m_lk[i] = 0; m_id[i] = 0; m_age[i] = 0;
      end
      m_cnt = 0; rsv_v = 0; rsv_ln = 0; next_id = 0; wd_act = 0; wd_tmr = 0; m_dead = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      chk("R4 outstanding after reset", int'(outstanding), 0);
      chk("R13 iss_valid after reset", int'(iss_valid), 0);
      chk("R5 deadlock after reset", int'(deadlock), 0);
      chk("R12 req_id after reset", int'(req_id), 0);
   endtask

   task automatic do_cycle(input bit v, input int kind, input int mode, input int line,
                           input bit rv, input bit rw, input int rline);
      bit rdy, acc, held, fail, ins, hit, setr, aged_any;
      int rid, cnt_new;
      @(negedge clk);
      req_valid = v; req_kind = 3'(kind); req_mode = 2'(mode); req_line = LINE_W'(line);
      rsp_valid = rv; rsp_write = rw; rsp_line = LINE_W'(rline);
      #1;
      rdy = (m_cnt < MAXO) && !m_v[line] &&
            (tcount(is_wr(kind)) < (is_wr(kind) ? WR_D : RD_D));
      if (v) chk("R2 R3 req_ready", int'(req_ready), int'(rdy));
      acc = v && rdy;
      if (acc) chk("R12 req_id", int'(req_id), next_id);
      held = rsv_v && rsv_ln == line;
      fail = acc && kind == 4 && !held;
      ins  = acc && !fail;
      hit  = rv && m_v[rline] && m_w[rline] == rw;
      rid  = m_id[rline];
      setr = hit && rw && m_lk[rline];
      aged_any = 0;
      for (int i = 0; i < NL; i++) if (m_v[i] && m_age[i] >= THR - 1) aged_any = 1;
      cnt_new = m_cnt + int'(ins) - int'(hit);
      @(posedge clk);
      #1;
      // model update
      for (int i = 0; i < NL; i++) if (m_v[i]) m_age[i]++;
      if (hit) m_v[rline] = 0;
      if (ins) begin
         m_v[line] = 1; m_w[line] = is_wr(kind); m_lk[line] = (kind == 3);
         m_id[line] = next_id; m_age[line] = 0;
      end
      if (setr) begin rsv_v = 1; rsv_ln = rline; end
      else if (acc && kind == 4 && held) rsv_v = 0;
      if (!wd_act) begin
         if (ins) begin wd_act = 1; wd_tmr = THR - 1; end
      end else if (wd_tmr == 0) begin
         if (aged_any) m_dead = 1;
         if (cnt_new != 0) wd_tmr = THR - 1; else wd_act = 0;
      end else wd_tmr--;
      m_cnt = cnt_new;
      // checks
      chk("R13 iss_valid", int'(iss_valid), int'(ins));
      if (ins) begin
         chk("R9 iss_kind", int'(iss_kind), kind == 1 ? 1 : (is_wr(kind) ? 2 : 0));
         chk("R9 iss_super", int'(iss_super), int'(mode == 1));
         chk("R10 iss_lat", int'(iss_lat), kind == 1 ? ILAT : DLAT);
         chk("R12 iss_id", int'(iss_id), next_id);
         chk("R13 iss_line", int'(iss_line), line);
      end
      chk("R8 lkfail_valid", int'(lkfail_valid), int'(fail));
      if (fail) chk("R8 lkfail_id", int'(lkfail_id), next_id);
      chk("R1 done_valid", int'(done_valid), int'(hit));
      if (hit) chk("R13 done_id", int'(done_id), rid);
      chk("R11 proto_err", int'(proto_err), int'(rv && !hit));
      chk("R4 outstanding", int'(outstanding), m_cnt);
      chk("R5 R6 deadlock", int'(deadlock), int'(m_dead));
      if (acc) next_id = (next_id + 1) % (1 << ID_W);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) do_cycle(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      do_reset();

      // R9 R10: each kind and mode code
      do_cycle(1, 0, 2, 1, 0, 0, 0);   // load, device -> user
      do_cycle(1, 1, 1, 2, 0, 0, 0);   // ifetch, supervisor
      do_cycle(1, 2, 0, 3, 0, 0, 0);   // store
      do_cycle(1, 0, 0, 1, 0, 0, 0);   // R3 same line refused
      do_cycle(1, 2, 0, 1, 0, 0, 0);   // R3 same line, other class refused
      do_cycle(1, 2, 3, 4, 0, 0, 0);   // store, fills MAX_OUT
      do_cycle(1, 0, 0, 5, 0, 0, 0);   // R2 global limit refuses
      // R11: wrong class and absent line
      do_cycle(0, 0, 0, 0, 1, 1, 1);
      do_cycle(0, 0, 0, 0, 1, 0, 9);
      // R1 R13 completions
      do_cycle(0, 0, 0, 0, 1, 0, 1);
      do_cycle(0, 0, 0, 0, 1, 0, 2);
      do_cycle(0, 0, 0, 0, 1, 1, 3);
      do_cycle(0, 0, 0, 0, 1, 1, 4);
      chk("R4 drained", int'(outstanding), 0);
      // R2 read table full while the global limit has room
      do_cycle(1, 0, 0, 6, 0, 0, 0);
      do_cycle(1, 1, 0, 7, 0, 0, 0);
      do_cycle(1, 0, 0, 8, 0, 0, 0);
      do_cycle(1, 0, 0, 9, 0, 0, 0);   // refused: read table full
      do_cycle(1, 2, 0, 9, 1, 0, 6);   // store accepted, completion same cycle
      do_cycle(0, 0, 0, 0, 1, 0, 7);
      do_cycle(0, 0, 0, 0, 1, 0, 8);
      do_cycle(0, 0, 0, 0, 1, 1, 9);
      // R7 R8 reservation
      do_cycle(1, 4, 0, 10, 0, 0, 0);  // no reservation: fails
      do_cycle(1, 3, 0, 10, 0, 0, 0);  // locked read
      do_cycle(0, 0, 0, 0, 1, 1, 10);  // sets reservation
      do_cycle(1, 4, 0, 11, 0, 0, 0);  // other line: fails
      do_cycle(1, 4, 0, 10, 0, 0, 0);  // held: issued, cleared
      do_cycle(0, 0, 0, 0, 1, 1, 10);
      do_cycle(1, 4, 0, 10, 0, 0, 0);  // cleared: fails again
      do_cycle(1, 3, 0, 12, 0, 0, 0);
      do_cycle(1, 3, 0, 13, 0, 0, 0);
      do_cycle(0, 0, 0, 0, 1, 1, 12);
      do_cycle(0, 0, 0, 0, 1, 1, 13);  // R7 later reservation replaces
      do_cycle(1, 4, 0, 12, 0, 0, 0);  // fails
      do_cycle(1, 4, 0, 13, 0, 0, 0);  // issued
      do_cycle(0, 0, 0, 0, 1, 1, 13);

      // R6: completion before threshold leaves no deadlock, watchdog re-arms
      do_reset();
      do_cycle(1, 0, 0, 3, 0, 0, 0);
      idle(3);
      do_cycle(0, 0, 0, 0, 1, 0, 3);
      idle(3 * THR);
      do_cycle(1, 2, 0, 4, 0, 0, 0);
      idle(THR / 2);
      do_cycle(0, 0, 0, 0, 1, 1, 4);
      idle(2 * THR);
      chk("R6 no deadlock when drained", int'(deadlock), 0);

      // R5: entry inserted mid-period is caught at the second check
      do_reset();
      do_cycle(1, 0, 0, 1, 0, 0, 0);   // edge E0 arms
      idle(4);
      do_cycle(1, 2, 0, 2, 0, 0, 0);   // edge E5
      idle(2);
      do_cycle(0, 0, 0, 0, 1, 0, 1);   // edge E8
      idle(2 * THR - 9);               // through edge E(2T-1)
      chk("R5 no deadlock before second check", int'(deadlock), 0);
      idle(1);                         // edge E(2T)
      chk("R5 deadlock at second check", int'(deadlock), 1);
      idle(3);

      // random phase
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         bit v, rv, rw;
         int k, md, ln, rl, st;
         v  = ($urandom % 4) != 0;
         k  = $urandom % 5;
         md = $urandom % 4;
         ln = $urandom % NL;
         rv = ($urandom % 2) == 0;
         rl = $urandom % NL;
         rw = $urandom % 2;
         if (($urandom % 100) < 85) begin
            st = $urandom % NL;
            for (int j = 0; j < NL; j++) begin
               if (m_v[(st + j) % NL]) begin
                  rl = (st + j) % NL;
                  rw = m_w[rl];
                  break;
               end
            end
         end
         do_cycle(v, k, md, ln, rv, rw, rl);
      end
      finish_run();
   end

endmodule